// File: doc/BRIEF.md
# Interrupt Acceptance and End-of-Interrupt Unit

This block sits behind a bank of interrupt input pins and decides, pin by pin, when an interrupt message leaves on a single delivery port. Each pin has a redirection entry written through a simple write port. The entry holds a vector, an input polarity, a trigger mode (edge or level), a mask bit, a destination and its addressing mode, and a delivery-mode code. The unit keeps a request bit and a remote-request bit for every pin. Edge pins fire once per inactive-to-active transition. Level pins fire and then stay blocked until a processor returns an end-of-interrupt (EOI) naming their vector.

When several pins are ready at once, a fixed-priority arbiter favours the lowest pin number. The chosen message is placed in an output register that is handed off with a valid/ready handshake. If an assertion on a pin arrives while that pin's earlier request is still outstanding, the unit reports it as coalesced. EOIs are first screened against a 256-entry record of the vectors currently programmed. This record is rebuilt one cycle after every table write.

Top module: `irq_accept_eoi`

## Requirements
- R1: A pin is active when its input level XOR the entry's polarity bit (1 = active low) is 1, and the delivered message carries that entry's vector.
- R2: An edge-mode pin (trigger bit 0) produces exactly one delivery for each inactive-to-active transition. A pin held active, or a falling transition, produces none.
- R3: An edge-mode pin that turns active again while its earlier request is still waiting produces a one-cycle pulse on its `coalesced` bit, and only one delivery results.
- R4: A level-mode pin (trigger bit 1) that is active with its remote-request bit clear is delivered once, and launching it sets the remote-request bit. While that bit is set, no further delivery occurs. A new activation in that state pulses `coalesced`.
- R5: A masked pin (mask bit 1) is never delivered, and writing the mask bit to 1 discards that pin's waiting request.
- R6: A delivered message carries the entry's destination, destination mode (1 = logical), 3-bit delivery mode and trigger mode, with `out_assert` at 1.
- R7: Pin 0 is always delivered with destination mode 0 (physical) and destination equal to parameter `BOOT_ID`, whatever its entry holds.
- R8: A level-type EOI (`eoi_level` = 1) clears the remote-request bit of every entry whose vector equals `eoi_vector`. A pin that is then still active and unmasked is delivered again. An edge-type EOI clears nothing.
- R9: An EOI whose vector appears in no entry has no effect.
- R10: Writing an entry clears its remote-request bit. A level-mode pin that is active and unmasked after the write is therefore delivered again.
- R11: Among pins waiting in the same cycle, the lowest-numbered pin is launched first, and the rest follow in ascending order as the output is accepted.
- R12: While `out_valid` is 1 and `out_ready` is 0, the output message is held unchanged.
- R13: After reset, every entry is masked, `out_valid` is 0 and no `coalesced` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Raw interrupt pin levels |
| cfg_we | input | 1 | Redirection entry write strobe |
| cfg_pin | input | IDX_W | Entry being written |
| cfg_vector | input | 8 | Vector to write |
| cfg_dmode | input | 3 | Delivery mode to write |
| cfg_dest_logical | input | 1 | Destination mode to write (1 = logical) |
| cfg_polarity | input | 1 | Polarity to write (1 = active low) |
| cfg_level | input | 1 | Trigger mode to write (1 = level) |
| cfg_mask | input | 1 | Mask bit to write (1 = masked) |
| cfg_dest | input | 8 | Destination to write |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector named by the EOI |
| eoi_level | input | 1 | EOI type (1 = level) |
| out_valid | output | 1 | Delivery message valid |
| out_ready | input | 1 | Downstream accepts the message |
| out_pin | output | IDX_W | Pin that raised the message |
| out_vector | output | 8 | Message vector |
| out_dest | output | 8 | Message destination |
| out_dest_logical | output | 1 | Message destination mode |
| out_dmode | output | 3 | Message delivery mode |
| out_level_trig | output | 1 | Message trigger mode |
| out_assert | output | 1 | Message level, always asserted |
| coalesced | output | NUM_PINS | Per-pin coalesced-event pulse |

## Verification
A remote-request bit stuck high shows as a level pin that never fires again after an EOI. A bit stuck low shows as a repeated delivery about three cycles after the first. A corrupted request bit turns a held edge input into a stream of messages, or silences a transition. Either fault is visible at the output within a few cycles. A faulty waiting-request bit shows in the order or count of messages once the output is released. A stale vector record shows as an EOI that fails to re-arm a level pin.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int DMODE_W = 3;
  localparam int NVEC    = 1 << VEC_W;

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DMODE_W-1:0] dmode;
    logic               dest_logical;
    logic               polarity;
    logic               level_trig;
    logic               mask;
    logic [DEST_W-1:0]  dest;
  } redir_t;
endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic polarity,
  input  logic level_trig,
  input  logic mask,
  input  logic grant,
  input  logic eoi_clr,
  input  logic wr_hit,
  input  logic wr_mask,
  output logic pend,
  output logic remote,
  output logic coal
);
  logic active, irr_q, rising;
  logic edge_req, lvl_req, drop, coal_d, pend_d;

  assign active = raw ^ polarity;
  assign rising = active & ~irr_q;
  assign drop   = wr_hit & wr_mask;

  always_comb begin
    edge_req = ~level_trig & rising & ~pend & ~mask & ~drop;
    lvl_req  = level_trig & active & ~remote & ~pend & ~mask & ~drop;
    coal_d   = rising & (pend | (level_trig & remote));
    pend_d   = (pend & ~grant & ~drop & ~(level_trig & ~active))
             | edge_req | lvl_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= 1'b0;
      pend   <= 1'b0;
      remote <= 1'b0;
      coal   <= 1'b0;
    end else begin
      irr_q <= active;
      pend  <= pend_d;
      coal  <= coal_d;
      if (grant && level_trig)
        remote <= 1'b1;
      else if (eoi_clr || wr_hit)
        remote <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vec_filter.sv
module irq_vec_filter
  import irq_accept_pkg::*;
#(
  parameter int NUM_PINS = 8
)(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rebuild,
  input  logic [NUM_PINS-1:0][VEC_W-1:0]  vecs,
  input  logic [VEC_W-1:0]                query,
  output logic                            hit
);
  logic [NVEC-1:0] seen_q, seen_d;

  always_comb begin
    seen_d = '0;
    for (int i = 0; i < NUM_PINS; i++)
      seen_d[vecs[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      seen_q <= NVEC'(1);
    else if (rebuild)
      seen_q <= seen_d;
  end

  assign hit = seen_q[query];
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N     = 8,
  parameter int IDX_W = 3
)(
  input  logic             en,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        found    = 1'b1;
        grant[i] = en;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_accept_eoi.sv
module irq_accept_eoi
  import irq_accept_pkg::*;
#(
  parameter int                NUM_PINS = 8,
  parameter logic [DEST_W-1:0] BOOT_ID  = 8'h00,
  localparam int               IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_pin,
  input  logic [VEC_W-1:0]    cfg_vector,
  input  logic [DMODE_W-1:0]  cfg_dmode,
  input  logic                cfg_dest_logical,
  input  logic                cfg_polarity,
  input  logic                cfg_level,
  input  logic                cfg_mask,
  input  logic [DEST_W-1:0]   cfg_dest,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic                eoi_level,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [IDX_W-1:0]    out_pin,
  output logic [VEC_W-1:0]    out_vector,
  output logic [DEST_W-1:0]   out_dest,
  output logic                out_dest_logical,
  output logic [DMODE_W-1:0]  out_dmode,
  output logic                out_level_trig,
  output logic                out_assert,
  output logic [NUM_PINS-1:0] coalesced
);
  localparam redir_t RST_ENT = '{mask: 1'b1, default: '0};

  redir_t                         tbl [NUM_PINS];
  redir_t                         wr_ent, pick;
  logic                           wr_ok, rebuild_q, eoi_hit, slot_free;
  logic [NUM_PINS-1:0]            pend_vec, remote_vec, mask_vec, level_vec;
  logic [NUM_PINS-1:0]            grant_vec, eoi_clr, wr_hit;
  logic [NUM_PINS-1:0][VEC_W-1:0] vec_bus;
  logic [IDX_W-1:0]               gidx;
  logic                           gfound;

  assign wr_ent = '{vector: cfg_vector, dmode: cfg_dmode,
                    dest_logical: cfg_dest_logical, polarity: cfg_polarity,
                    level_trig: cfg_level, mask: cfg_mask, dest: cfg_dest};
  assign wr_ok  = cfg_we && (int'(cfg_pin) < NUM_PINS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++)
        tbl[i] <= RST_ENT;
      rebuild_q <= 1'b0;
    end else begin
      if (wr_ok)
        tbl[cfg_pin] <= wr_ent;
      rebuild_q <= wr_ok;
    end
  end

  irq_vec_filter #(.NUM_PINS(NUM_PINS)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .rebuild (rebuild_q),
    .vecs    (vec_bus),
    .query   (eoi_vector),
    .hit     (eoi_hit)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign vec_bus[g]   = tbl[g].vector;
    assign mask_vec[g]  = tbl[g].mask;
    assign level_vec[g] = tbl[g].level_trig;
    assign eoi_clr[g]   = eoi_valid && eoi_level && eoi_hit
                          && (tbl[g].vector == eoi_vector);
    assign wr_hit[g]    = wr_ok && (cfg_pin == IDX_W'(g));

    irq_pin_slice u_slice (
      .clk        (clk),
      .rst        (rst),
      .raw        (pin_in[g]),
      .polarity   (tbl[g].polarity),
      .level_trig (tbl[g].level_trig),
      .mask       (tbl[g].mask),
      .grant      (grant_vec[g]),
      .eoi_clr    (eoi_clr[g]),
      .wr_hit     (wr_hit[g]),
      .wr_mask    (cfg_mask),
      .pend       (pend_vec[g]),
      .remote     (remote_vec[g]),
      .coal       (coalesced[g])
    );
  end

  assign slot_free = !out_valid || out_ready;

  irq_prio_arb #(.N(NUM_PINS), .IDX_W(IDX_W)) u_arb (
    .en    (slot_free),
    .req   (pend_vec & ~mask_vec),
    .grant (grant_vec),
    .idx   (gidx),
    .found (gfound)
  );

  assign pick = tbl[gidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid        <= 1'b0;
      out_pin          <= '0;
      out_vector       <= '0;
      out_dest         <= '0;
      out_dest_logical <= 1'b0;
      out_dmode        <= '0;
      out_level_trig   <= 1'b0;
      out_assert       <= 1'b0;
    end else if (slot_free && gfound) begin
      out_valid        <= 1'b1;
      out_pin          <= gidx;
      out_vector       <= pick.vector;
      out_dmode        <= pick.dmode;
      out_level_trig   <= pick.level_trig;
      out_assert       <= 1'b1;
      if (gidx == '0) begin
        out_dest         <= BOOT_ID;
        out_dest_logical <= 1'b0;
      end else begin
        out_dest         <= pick.dest;
        out_dest_logical <= pick.dest_logical;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_accept_eoi_chk.sv
module irq_accept_eoi_chk #(
  parameter int          NUM_PINS = 8,
  parameter int          IDX_W    = 3,
  parameter logic [7:0]  BOOT_ID  = 8'h00
)(
  input logic                clk,
  input logic                rst,
  input logic                out_valid,
  input logic                out_ready,
  input logic [IDX_W-1:0]    out_pin,
  input logic [7:0]          out_vector,
  input logic [7:0]          out_dest,
  input logic                out_dest_logical,
  input logic                out_assert,
  input logic [NUM_PINS-1:0] grant_vec,
  input logic [NUM_PINS-1:0] remote_vec,
  input logic [NUM_PINS-1:0] level_vec
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk)
    if (rst_d && !rst)
      AST_IDLE_AFTER_RST: assert (!out_valid); // R13

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_vector) && $stable(out_pin) && $stable(out_dest)); // R12

  AST_PIN0_BOOT: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_pin == '0) |-> (out_dest == BOOT_ID) && !out_dest_logical); // R7

  AST_ASSERT_HIGH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_assert); // R6

  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec)); // R11

  AST_NO_REMOTE_GRANT: assert property (@(posedge clk) disable iff (rst)
    (grant_vec & remote_vec & level_vec) == '0); // R4

  AST_REMOTE_SET: assert property (@(posedge clk) disable iff (rst)
    (|(grant_vec & level_vec)) |=>
      ((remote_vec & $past(grant_vec & level_vec)) == $past(grant_vec & level_vec))); // R4
endmodule

bind irq_accept_eoi irq_accept_eoi_chk #(
  .NUM_PINS (NUM_PINS),
  .IDX_W    (IDX_W),
  .BOOT_ID  (BOOT_ID)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_pin          (out_pin),
  .out_vector       (out_vector),
  .out_dest         (out_dest),
  .out_dest_logical (out_dest_logical),
  .out_assert       (out_assert),
  .grant_vec        (grant_vec),
  .remote_vec       (remote_vec),
  .level_vec        (level_vec)
);

// File: tb/irq_accept_eoi_tb.sv
`timescale 1ns/1ps
module irq_accept_eoi_tb;
  localparam int         NP   = 8;
  localparam logic [7:0] BOOT = 8'hA5;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_in;
  logic          cfg_we;
  logic [2:0]    cfg_pin;
  logic [7:0]    cfg_vector;
  logic [2:0]    cfg_dmode;
  logic          cfg_dest_logical, cfg_polarity, cfg_level, cfg_mask;
  logic [7:0]    cfg_dest;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          eoi_level;
  logic          out_valid, out_ready;
  logic [2:0]    out_pin;
  logic [7:0]    out_vector, out_dest;
  logic          out_dest_logical, out_level_trig, out_assert;
  logic [2:0]    out_dmode;
  logic [NP-1:0] coalesced;

  always #4 clk = ~clk;

  irq_accept_eoi #(.NUM_PINS(NP), .BOOT_ID(BOOT)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_vector(cfg_vector),
    .cfg_dmode(cfg_dmode), .cfg_dest_logical(cfg_dest_logical),
    .cfg_polarity(cfg_polarity), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .cfg_dest(cfg_dest), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .out_valid(out_valid), .out_ready(out_ready),
    .out_pin(out_pin), .out_vector(out_vector), .out_dest(out_dest),
    .out_dest_logical(out_dest_logical), .out_dmode(out_dmode),
    .out_level_trig(out_level_trig), .out_assert(out_assert),
    .coalesced(coalesced)
  );

  int qpin[$], qvec[$], qdest[$], qdlog[$], qdm[$], qlvl[$], qas[$];
  int coal_cnt [NP];
  int total = 0, bad = 0, base = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (rst === 1'b0) begin
      if (out_valid && out_ready) begin
        qpin.push_back(int'(out_pin));
        qvec.push_back(int'(out_vector));
        qdest.push_back(int'(out_dest));
        qdlog.push_back(int'(out_dest_logical));
        qdm.push_back(int'(out_dmode));
        qlvl.push_back(int'(out_level_trig));
        qas.push_back(int'(out_assert));
      end
      for (int i = 0; i < NP; i++)
        if (coalesced[i]) coal_cnt[i]++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int p, input int vec, input int dm, input int dlog,
                    input int pol, input int lvl, input int msk, input int dst);
    cfg_we = 1'b1; cfg_pin = 3'(p); cfg_vector = 8'(vec); cfg_dmode = 3'(dm);
    cfg_dest_logical = 1'(dlog); cfg_polarity = 1'(pol); cfg_level = 1'(lvl);
    cfg_mask = 1'(msk); cfg_dest = 8'(dst);
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic send_eoi(input int vec, input int lvl);
    eoi_valid = 1'b1; eoi_vector = 8'(vec); eoi_level = 1'(lvl);
    step(1);
    eoi_valid = 1'b0;
  endtask

  function automatic int cnt();
    return qpin.size() - base;
  endfunction

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cb;
    int v0;
    rst = 1'b1; pin_in = '0; cfg_we = 1'b0; cfg_pin = '0; cfg_vector = '0;
    cfg_dmode = '0; cfg_dest_logical = 1'b0; cfg_polarity = 1'b0;
    cfg_level = 1'b0; cfg_mask = 1'b0; cfg_dest = '0; eoi_valid = 1'b0;
    eoi_vector = '0; eoi_level = 1'b0; out_ready = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    // R13: idle after reset, all entries masked
    check("R13 out_valid after reset", int'(out_valid), 0);
    check("R13 coalesced after reset", int'(coalesced), 0);
    base = qpin.size();
    pin_in[1] = 1'b1;
    step(6);
    check("R13 masked reset entry no delivery", cnt(), 0);
    pin_in[1] = 1'b0;
    step(3);

    // R1 R2 R6: sweep pins 1..7, both polarities, edge mode
    for (int p = 1; p < NP; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(p, 32 + p, p % 8, p % 2, pol, 0, 1, 16 + p);
        pin_in[p] = 1'(pol);
        step(3);
        wr(p, 32 + p, p % 8, p % 2, pol, 0, 0, 16 + p);
        step(3);
        base = qpin.size();
        pin_in[p] = 1'(1 - pol);
        step(6);
        check("R2 one delivery per activation", cnt(), 1);
        if (cnt() == 1) begin
          check("R1 vector", qvec[base], 32 + p);
          check("R6 destination", qdest[base], 16 + p);
          check("R6 destination mode", qdlog[base], p % 2);
          check("R6 delivery mode", qdm[base], p % 8);
          check("R6 trigger mode", qlvl[base], 0);
          check("R6 assert level", qas[base], 1);
        end
        step(6);
        check("R2 held active no repeat", cnt(), 1);
        pin_in[p] = 1'(pol);
        step(6);
        check("R1 falling no delivery", cnt(), 1);
        wr(p, 32 + p, 0, 0, pol, 0, 1, 0);
      end
    end
    pin_in = '0;
    step(3);

    // R7: pin 0 forced to physical boot destination
    wr(0, 48, 2, 1, 0, 0, 0, 51);
    step(3);
    base = qpin.size();
    pin_in[0] = 1'b1;
    step(6);
    check("R7 pin0 delivered", cnt(), 1);
    if (cnt() == 1) begin
      check("R7 pin0 dest is boot id", qdest[base], int'(BOOT));
      check("R7 pin0 physical mode", qdlog[base], 0);
      check("R1 pin0 vector", qvec[base], 48);
    end
    pin_in[0] = 1'b0;
    wr(0, 48, 2, 1, 0, 0, 1, 51);
    step(3);

    // R4 R8 R9: level pin 3 with remote-request handshake
    wr(3, 67, 0, 0, 0, 1, 0, 3);
    step(3);
    base = qpin.size();
    cb = coal_cnt[3];
    pin_in[3] = 1'b1;
    step(6);
    check("R4 level first delivery", cnt(), 1);
    if (cnt() == 1) check("R6 level trigger mode", qlvl[base], 1);
    step(6);
    check("R4 blocked while remote set", cnt(), 1);
    pin_in[3] = 1'b0;
    step(2);
    pin_in[3] = 1'b1;
    step(6);
    check("R4 reactivation not delivered", cnt(), 1);
    check("R4 reactivation coalesced", coal_cnt[3] - cb, 1);
    send_eoi(153, 1);
    step(6);
    check("R9 unknown vector EOI ignored", cnt(), 1);
    send_eoi(67, 0);
    step(6);
    check("R8 edge EOI clears nothing", cnt(), 1);
    send_eoi(67, 1);
    step(6);
    check("R8 level EOI redelivers", cnt(), 2);
    pin_in[3] = 1'b0;
    step(2);
    send_eoi(67, 1);
    step(6);
    check("R8 EOI with inactive pin no delivery", cnt(), 2);
    pin_in[3] = 1'b1;
    step(6);
    check("R8 remote cleared then activation delivers", cnt(), 3);

    // R10 R5: table write re-evaluation and masking
    wr(3, 67, 0, 0, 0, 1, 0, 3);
    step(6);
    check("R10 write redelivers active level pin", cnt(), 4);
    wr(3, 67, 0, 0, 0, 1, 1, 3);
    step(2);
    send_eoi(67, 1);
    step(6);
    check("R5 masked level pin not delivered", cnt(), 4);
    wr(3, 67, 0, 0, 0, 1, 0, 3);
    step(6);
    check("R10 unmask write delivers", cnt(), 5);
    wr(3, 67, 0, 0, 0, 1, 1, 3);
    pin_in[3] = 1'b0;
    step(3);

    // R11 R12: priority and output hold
    wr(2, 82, 0, 0, 0, 0, 0, 2);
    wr(5, 85, 0, 0, 0, 0, 0, 5);
    wr(6, 86, 0, 0, 0, 0, 0, 6);
    step(3);
    out_ready = 1'b0;
    base = qpin.size();
    pin_in[2] = 1'b1; pin_in[5] = 1'b1; pin_in[6] = 1'b1;
    step(4);
    check("R11 output valid", int'(out_valid), 1);
    check("R11 lowest pin first", int'(out_pin), 2);
    v0 = int'(out_vector);
    step(3);
    check("R12 valid held", int'(out_valid), 1);
    check("R12 vector held", int'(out_vector), v0);
    check("R12 pin held", int'(out_pin), 2);
    out_ready = 1'b1;
    step(8);
    check("R11 three deliveries", cnt(), 3);
    if (cnt() == 3) begin
      check("R11 order first", qpin[base], 2);
      check("R11 order second", qpin[base + 1], 5);
      check("R11 order third", qpin[base + 2], 6);
    end
    pin_in = '0;
    step(3);

    // R3 R5: edge coalescing and mask drop of waiting request
    out_ready = 1'b0;
    base = qpin.size();
    cb = coal_cnt[5];
    pin_in[2] = 1'b1;
    step(4);
    pin_in[5] = 1'b1;
    step(2);
    pin_in[5] = 1'b0;
    step(2);
    pin_in[5] = 1'b1;
    step(3);
    check("R3 edge coalesced pulse", coal_cnt[5] - cb, 1);
    pin_in[6] = 1'b1;
    step(3);
    wr(6, 86, 0, 0, 0, 0, 1, 6);
    step(2);
    out_ready = 1'b1;
    step(8);
    check("R5 masked request dropped", cnt(), 2);
    if (cnt() == 2) begin
      check("R3 first delivery pin", qpin[base], 2);
      check("R3 single delivery for pin5", qpin[base + 1], 5);
    end
    pin_in = '0;
    step(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule